// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a subroutine return will land. Each cycle the issue stage may present one instruction together with its program counter. The block decodes that instruction and classifies it as a call, a return, both, or neither. A call pushes the address of the instruction that follows it, which is the PC plus 2 for a compressed encoding and plus 4 otherwise. A return pops the newest saved address and latches it as the prediction.

The prediction register keeps the last popped address until the next return or a flush. The fetch logic compares it with the real target of an indirect jump. When no prediction is valid, the target reads as zero, so any indirect jump that is not backed by a stored return address mispredicts. Only `DEPTH-1` addresses are stored. A push into a full stack throws away the oldest entry, so the most recent call nesting is kept.

Top module: `rstk_predictor`

## Requirements
- R1: After reset, `pred_valid` is 0, `pred_target` is 0 and `occupancy` is 0.
- R2: `cls_call` is 1 for these encodings and 0 for all others:
  - a 32-bit instruction with opcode bits [6:0] = 1101111 or 1100111 whose rd (bits [11:7]) is 1 or 5;
  - a 16-bit instruction with bits [1:0] = 01 and bits [15:13] = 001;
  - a 16-bit instruction with bits [1:0] = 10, bits [15:12] = 1001, bits [6:2] = 0 and bits [11:7] not 0.
- R3: `cls_ret` is 1 for these encodings and 0 for all others:
  - a 32-bit instruction with opcode 1100111 whose rs1 (bits [19:15]) is 1 or 5 and differs from rd;
  - a 16-bit instruction with bits [1:0] = 10, bits [15:13] = 100 and bits [6:2] = 0, whose bits [11:7] are 1 or 5.
- R4: A call that is accepted (`issue_valid` high, `flush` low) pushes `issue_pc`+2 when `issue_instr[1:0]` is not 11, and `issue_pc`+4 otherwise.
- R5: `occupancy` never exceeds `DEPTH-1`. A push into a full stack discards the oldest entry and keeps the newer ones in order.
- R6: An accepted return on a non-empty stack removes the newest entry. On the next cycle it shows that entry on `pred_target` with `pred_valid` high, and both hold until the next return or flush.
- R7: An accepted return on an empty stack makes `pred_valid` 0 and `pred_target` 0 on the next cycle.
- R8: An instruction that is both a return and a call pops first and then pushes. The prediction is the previous top entry, and the stack afterwards holds the new return address in place of the popped one.
- R9: An instruction that is neither a call nor a return, or any instruction presented with `issue_valid` low, leaves `occupancy`, `pred_valid` and `pred_target` unchanged.
- R10: `flush` empties the stack and invalidates the prediction on the next cycle. It overrides any call or return presented in the same cycle.
- R11: Whenever `pred_valid` is 0, `pred_target` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the stack and drops the prediction |
| issue_valid | input | 1 | An instruction is issued this cycle |
| issue_pc | input | XLEN | Address of the issued instruction |
| issue_instr | input | 32 | Encoding of the issued instruction; 16-bit forms sit in bits [15:0] |
| cls_call | output | 1 | Decoded as a call (not gated by `issue_valid`) |
| cls_ret | output | 1 | Decoded as a return (not gated by `issue_valid`) |
| pred_valid | output | 1 | The predicted return target is backed by a stored entry |
| pred_target | output | XLEN | Predicted return target, 0 when invalid |
| occupancy | output | CNT_W | Number of stored return addresses |

## Verification
The decoder is swept over every rd/rs1 pair of the 32-bit register jump, every rd of the 32-bit direct jump, and every register field of the two 16-bit register jumps. This separates the link-register rule, the rs1-equals-rd exclusion and the zero-register case of the 16-bit form. Every swept instruction is also issued, so the stack state is compared against an arithmetic reference throughout.

Directed sequences cover the following cases:
- overfilling the stack, then draining it, which shows oldest-first discard and newest-first return order;
- pops on an empty stack;
- an instruction that pops and pushes at once, which shows the pop-before-push order;
- instructions that are neither calls nor returns, and instructions presented without `issue_valid`, which must leave all state untouched;
- a flush that arrives together with a call.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef struct packed {
    logic call;
    logic ret;
  } rstk_cls_t;

  function automatic logic rstk_is_link(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

  function automatic logic rstk_is_short(input logic [1:0] q);
    return q != 2'b11;
  endfunction

  // Byte distance to the next sequential instruction.
  function automatic logic [2:0] rstk_step(input logic [1:0] q);
    return rstk_is_short(q) ? 3'd2 : 3'd4;
  endfunction

  function automatic rstk_cls_t rstk_classify(input logic [31:0] ins);
    rstk_cls_t c;
    logic       sh;
    logic       jal32, jalr32, cjal, cjr, cjalr;
    logic [4:0] rd, rs1, crs2;
    sh     = rstk_is_short(ins[1:0]);
    rd     = ins[11:7];
    rs1    = ins[19:15];
    crs2   = ins[6:2];
    jal32  = !sh && (ins[6:0] == 7'b1101111);
    jalr32 = !sh && (ins[6:0] == 7'b1100111);
    cjal   = (ins[1:0] == 2'b01) && (ins[15:13] == 3'b001);
    cjr    = (ins[1:0] == 2'b10) && (ins[15:12] == 4'b1000) && (crs2 == 5'd0);
    cjalr  = (ins[1:0] == 2'b10) && (ins[15:12] == 4'b1001) && (crs2 == 5'd0)
             && (rd != 5'd0);
    c.ret  = (jalr32 && rstk_is_link(rs1) && (rs1 != rd))
             || ((cjr || cjalr) && rstk_is_link(rd));
    c.call = cjal || cjalr || ((jal32 || jalr32) && rstk_is_link(rd));
    return c;
  endfunction

endpackage

// File: rtl/rstk_classify.sv
module rstk_classify
  import rstk_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  output logic            is_call,
  output logic            is_ret,
  output logic [XLEN-1:0] link_addr
);
  rstk_cls_t cls;
  logic      unused_imm;

  assign cls        = rstk_classify(instr);
  assign is_call    = cls.call;
  assign is_ret     = cls.ret;
  assign link_addr  = pc + XLEN'(rstk_step(instr[1:0]));
  assign unused_imm = ^instr[31:20];
endmodule

// File: rtl/rstk_lifo.sv
module rstk_lifo #(
  parameter int XLEN  = 32,
  parameter int CAP   = 1,
  parameter int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pop,
  input  logic             push,
  input  logic [XLEN-1:0]  push_addr,
  output logic [XLEN-1:0]  top_addr,
  output logic [CNT_W-1:0] count,
  output logic             drop_oldest
);
  logic [XLEN-1:0]  mem_q [CAP];
  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_d;
  logic             full_mid;

  // Pop is resolved first; a push then sees the reduced count.
  always_comb begin
    cnt_mid     = (pop && (cnt_q != '0)) ? cnt_q - 1'b1 : cnt_q;
    full_mid    = (cnt_mid == CNT_W'(CAP));
    drop_oldest = push && full_mid && !clr;
    if (clr)                   cnt_d = '0;
    else if (push && !full_mid) cnt_d = cnt_mid + 1'b1;
    else                       cnt_d = cnt_mid;
  end

  always_comb begin
    top_addr = '0;
    for (int k = 0; k < CAP; k++)
      if (cnt_q == CNT_W'(k + 1)) top_addr = mem_q[k];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  // Slot 0 is the oldest entry; a full push shifts toward slot 0.
  for (genvar i = 0; i < CAP; i++) begin : g_slot
    if (i == CAP - 1) begin : g_last
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) mem_q[i] <= '0;
        else if (!clr && push && (full_mid || cnt_mid == CNT_W'(i)))
          mem_q[i] <= push_addr;
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) mem_q[i] <= '0;
        else if (!clr && push) begin
          if (full_mid)                     mem_q[i] <= mem_q[i+1];
          else if (cnt_mid == CNT_W'(i))    mem_q[i] <= push_addr;
        end
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/rstk_predictor.sv
module rstk_predictor #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 2,
  parameter int CAP   = DEPTH - 1,
  parameter int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             issue_valid,
  input  logic [XLEN-1:0]  issue_pc,
  input  logic [31:0]      issue_instr,
  output logic             cls_call,
  output logic             cls_ret,
  output logic             pred_valid,
  output logic [XLEN-1:0]  pred_target,
  output logic [CNT_W-1:0] occupancy
);
  logic [XLEN-1:0] link_addr, top_addr;
  logic            ev_pop, ev_push, ev_drop;
  logic            pv_q;
  logic [XLEN-1:0] pa_q;

  rstk_classify #(.XLEN(XLEN)) u_cls (
    .instr(issue_instr), .pc(issue_pc),
    .is_call(cls_call), .is_ret(cls_ret), .link_addr(link_addr)
  );

  // Named events for the checker.
  assign ev_pop  = issue_valid && cls_ret  && !flush;
  assign ev_push = issue_valid && cls_call && !flush;

  rstk_lifo #(.XLEN(XLEN), .CAP(CAP), .CNT_W(CNT_W)) u_lifo (
    .clk(clk), .rst_n(rst_n), .clr(flush), .pop(ev_pop), .push(ev_push),
    .push_addr(link_addr), .top_addr(top_addr), .count(occupancy),
    .drop_oldest(ev_drop)
  );

  // Prediction holds the most recently popped address.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pv_q <= 1'b0;
      pa_q <= '0;
    end else if (flush) begin
      pv_q <= 1'b0;
      pa_q <= '0;
    end else if (ev_pop) begin
      pv_q <= (occupancy != '0);
      pa_q <= (occupancy != '0) ? top_addr : '0;
    end

  assign pred_valid  = pv_q;
  assign pred_target = pa_q;
endmodule

// File: rtl/rstk_checker.sv
module rstk_checker #(
  parameter int XLEN  = 32,
  parameter int CAP   = 1,
  parameter int CNT_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             ev_pop,
  input logic             ev_push,
  input logic             pred_valid,
  input logic [XLEN-1:0]  pred_target,
  input logic [CNT_W-1:0] occupancy
);
  p_zero_when_invalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> pred_target == '0);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(CAP));

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occupancy == '0) && !pred_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !ev_pop && !ev_push) |=>
      $stable(occupancy) && $stable(pred_valid) && $stable(pred_target));

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && occupancy == '0) |=> !pred_valid);

  p_pop_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && occupancy != '0) |=> pred_valid);

  p_push_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && !ev_pop && occupancy < CNT_W'(CAP)) |=>
      occupancy == $past(occupancy) + 1'b1);

  p_pop_push_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && ev_pop && occupancy != '0) |=> $stable(occupancy));
endmodule

bind rstk_predictor rstk_checker #(.XLEN(XLEN), .CAP(CAP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ev_pop(ev_pop), .ev_push(ev_push),
  .pred_valid(pred_valid), .pred_target(pred_target), .occupancy(occupancy)
);

// File: tb/tb_rstk_predictor.sv
`timescale 1ns/1ps
module tb_rstk_predictor;
  localparam int XLEN = 32;
  localparam int DEPTH = 4;
  localparam int CAP = DEPTH - 1;
  localparam int CNT_W = $clog2(CAP + 1);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, issue_valid = 1'b0;
  logic [XLEN-1:0] issue_pc = '0;
  logic [31:0] issue_instr = 32'h13;
  logic cls_call, cls_ret, pred_valid;
  logic [XLEN-1:0] pred_target;
  logic [CNT_W-1:0] occupancy;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] ref_stk [CAP];
  int ref_cnt = 0;
  bit ref_pv = 0;
  logic [31:0] ref_pa = '0;

  always #10 clk = ~clk;

  rstk_predictor #(.XLEN(XLEN), .DEPTH(DEPTH)) dut (.*);

  function automatic logic [31:0] e_jalr(int rd, int rs1);
    return {12'h0, 5'(rs1), 3'b000, 5'(rd), 7'b1100111};
  endfunction
  function automatic logic [31:0] e_jal(int rd);
    return {20'h0, 5'(rd), 7'b1101111};
  endfunction
  function automatic logic [31:0] e_cjr(int r);
    return {16'h0, 4'b1000, 5'(r), 5'd0, 2'b10};
  endfunction
  function automatic logic [31:0] e_cjalr(int r);
    return {16'h0, 4'b1001, 5'(r), 5'd0, 2'b10};
  endfunction
  localparam logic [31:0] C_JAL = {16'h0, 3'b001, 11'h0, 2'b01};
  localparam logic [31:0] ADDI  = 32'h0000_0013;

  function automatic bit lnk(int r);
    return r == 1 || r == 5;
  endfunction

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(pred_valid, ref_pv, {req, " pred_valid"});
    chk(pred_target, ref_pa, {req, " pred_target"});
    chk(occupancy, ref_cnt, {req, " occupancy"});
    if (!pred_valid) chk(pred_target, 0, "R11 target zero when invalid");
  endtask

  // Called at a negedge; returns at the next negedge with outputs checked.
  task automatic step(input logic [31:0] ins, input logic [31:0] pc, input bit v,
                      input bit fl, input bit ec, input bit er, input string req);
    logic [31:0] la;
    flush = fl; issue_valid = v; issue_pc = pc; issue_instr = ins;
    #1;
    chk(cls_call, ec, {req, " R2 call class"});
    chk(cls_ret, er, {req, " R3 return class"});
    la = pc + ((ins[1:0] != 2'b11) ? 32'd2 : 32'd4);
    if (fl) begin
      ref_cnt = 0; ref_pv = 0; ref_pa = '0;
    end else if (v) begin
      if (er) begin
        if (ref_cnt > 0) begin ref_pa = ref_stk[ref_cnt-1]; ref_pv = 1; ref_cnt--; end
        else begin ref_pa = '0; ref_pv = 0; end
      end
      if (ec) begin
        if (ref_cnt == CAP) begin
          for (int k = 0; k < CAP - 1; k++) ref_stk[k] = ref_stk[k+1];
          ref_stk[CAP-1] = la;
        end else begin
          ref_stk[ref_cnt] = la; ref_cnt++;
        end
      end
    end
    @(posedge clk); @(negedge clk);
    check_state(req);
    flush = 0; issue_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");

    // R7: return on an empty stack
    step(e_cjr(1), 32'h40, 1, 0, 0, 1, "R7 empty pop");
    // R4/R6: 32-bit call then return
    step(e_jal(1), 32'h100, 1, 0, 1, 0, "R4 push pc+4");
    step(e_jalr(0, 1), 32'h500, 1, 0, 0, 1, "R6 pop 0x104");
    chk(pred_target, 32'h104, "R4 pushed value pc+4");
    // R4: compressed call
    step(C_JAL, 32'h200, 1, 0, 1, 0, "R4 push pc+2");
    step(e_cjr(5), 32'h600, 1, 0, 0, 1, "R6 pop 0x202");
    chk(pred_target, 32'h202, "R4 pushed value pc+2");
    // R9: hold behaviour
    step(ADDI, 32'h700, 1, 0, 0, 0, "R9 neither");
    step(e_jal(1), 32'h800, 0, 0, 1, 0, "R9 issue_valid low");
    chk(pred_target, 32'h202, "R6 prediction held");
    // R5: overfill by two, then drain
    for (int i = 0; i < CAP + 2; i++)
      step(e_jal(5), 32'h1000 + 32'(i) * 32'h10, 1, 0, 1, 0, "R5 overfill");
    chk(occupancy, CAP, "R5 saturated occupancy");
    for (int i = CAP + 1; i >= 2; i--) begin
      step(e_jalr(0, 5), 32'h900, 1, 0, 0, 1, "R5 drain");
      chk(pred_target, 32'h1004 + 32'(i) * 32'h10, "R5 newest-first order");
    end
    step(e_jalr(0, 5), 32'h900, 1, 0, 0, 1, "R7 pop after drain");
    // R8: pop then push
    step(e_jal(1), 32'h2000, 1, 0, 1, 0, "R8 setup");
    step(e_jalr(1, 5), 32'h3000, 1, 0, 1, 1, "R8 pop and push");
    chk(pred_target, 32'h2004, "R8 prediction is old top");
    step(e_cjalr(1), 32'h3100, 1, 0, 1, 1, "R8 compressed pop and push");
    chk(pred_target, 32'h3004, "R8 second pop and push");
    step(e_jalr(0, 1), 32'h3200, 1, 0, 0, 1, "R8 final pop");
    chk(pred_target, 32'h3102, "R8 new entry replaced old");
    // R10: flush beats a call
    step(e_jal(1), 32'h4000, 1, 0, 1, 0, "R10 setup");
    step(e_jal(1), 32'h4100, 1, 1, 1, 0, "R10 flush with call");
    chk(occupancy, 0, "R10 flushed empty");

    // Sweep: 32-bit register jump, every rd/rs1 pair
    for (int rd = 0; rd < 32; rd++)
      for (int rs = 0; rs < 32; rs++)
        step(e_jalr(rd, rs), 32'h8000 + 32'(rd * 32 + rs) * 4, 1, 0,
             lnk(rd), lnk(rs) && rs != rd, "R3 jalr sweep");
    for (int rd = 0; rd < 32; rd++)
      step(e_jal(rd), 32'hA000 + 32'(rd) * 4, 1, 0, lnk(rd), 0, "R2 jal sweep");
    for (int r = 0; r < 32; r++) begin
      step(e_cjr(r), 32'hB000 + 32'(r) * 2, 1, 0, 0, lnk(r), "R3 c.jr sweep");
      step(e_cjalr(r), 32'hC000 + 32'(r) * 2, 1, 0, r != 0, lnk(r), "R2 c.jalr sweep");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule